// File: doc/BRIEF.md
# Instruction Prefetch Queue with Store Detection

This block is a small FIFO of prefetched instruction words that sits between the fetch unit and the decoder. Each word enters with the linear byte address it was fetched from. The decoder drains it in order. Both sides use a valid/ready handshake.

A store-monitor port shows every data store as a linear start address and a byte length. The block compares that store against every word it currently holds. When the store touches any held word, the whole queue is discarded. The block then tells the fetch unit to restart at the address of the oldest instruction the decoder has not yet taken. A taken branch redirect also empties the queue, and fetch restarts at the branch target. A serializing request empties the queue too, so that fetch re-reads memory.

A legacy input turns off the store comparison. In that mode, words that a store has made stale can still reach the decoder until a redirect empties the queue.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty: `outValid` is 0, `fillReady` is 1 and `restartValid` is 0.
- R2: A word is taken when `fillValid` and `fillReady` are both high. A word is handed over when `outValid` and `outReady` are both high. Words leave in arrival order with the same address and data.
- R3: The queue holds at most DEPTH words (8 by default). `fillReady` is low while DEPTH words are held, even in a cycle where one is being drained.
- R4: A store covers the bytes `storeAddr` to `storeAddr+storeLen`, so `storeLen` is the byte count minus one. A held word covers its address to its address plus 3. If `storeValid` is high, the mode is not legacy, and the store overlaps any held word, then `restartValid` rises in that same cycle and the whole queue is emptied.
- R5: On a flush caused by a store or by serialization, `restartAddr` is the address of the oldest held word. If the queue is empty, it is the address after the last word handed to the decoder. Before any word has been handed over, that value is RESET_ADDR, and after an earlier flush it is that flush's restart address.
- R6: `redirectValid` flushes the queue, and `restartAddr` equals `redirectAddr`. This takes priority over a store flush or a serialize flush in the same cycle.
- R7: `serialize` flushes the queue whether or not it holds any words.
- R8: While `legacyMode` is 1, stores never flush the queue. Held words, including overlapped ones, are still delivered.
- R9: In a flush cycle, `outValid` and `fillReady` are both low, so no word moves on either side. In the next cycle the queue is empty. If the decoder is ready in the same cycle that a store hits the oldest word, that word is not delivered, and `restartAddr` points at it.
- R10: A store that overlaps no held word, including any store while the queue is empty, changes nothing: no restart, and the same words are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | 1 disables store detection |
| fillValid | input | 1 | Fetch unit offers a word |
| fillReady | output | 1 | Queue accepts the offered word |
| fillAddr | input | AW | Linear address of the offered word |
| fillData | input | DW | Offered instruction word |
| outValid | output | 1 | Oldest word is available to the decoder |
| outReady | input | 1 | Decoder takes the word |
| outAddr | output | AW | Linear address of the oldest word |
| outData | output | DW | Oldest instruction word |
| storeValid | input | 1 | A data store is observed |
| storeAddr | input | AW | Linear start address of the store |
| storeLen | input | LENW | Store byte count minus one |
| redirectValid | input | 1 | Taken branch redirect |
| redirectAddr | input | AW | Branch target |
| serialize | input | 1 | Serializing request |
| restartValid | output | 1 | Queue flushed; fetch must restart |
| restartAddr | output | AW | Address where fetch restarts |

## Verification
The bench uses the default parameters: 8 entries, 32-bit words and addresses, and a 3-bit store length so that a store can span 1 to 8 bytes. RESET_ADDR is set to 0x1000. With only 8 entries the full-queue boundary is reached often. A store of up to 8 bytes can straddle two adjacent words or touch only the first or last byte of one, which exercises the edges of the overlap test. The random phase switches legacy mode on and off, aims stores near and inside the held addresses, and mixes in redirects and serialize requests. This brings same-cycle drain-and-hit and simultaneous flush causes within reach.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } pfq_strobe_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fillValid,
  input  logic          outReady,
  input  logic          storeHit,
  input  logic          legacyMode,
  input  logic          redirectValid,
  input  logic          serialize,
  output pfq_strobe_t   ctl,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] rdIdx,
  output logic          fillReady,
  output logic          outValid,
  output logic          queueEmpty
);
  logic [CW-1:0] count;
  logic          flushNow;

  assign flushNow   = (storeHit && !legacyMode) || redirectValid || serialize;
  assign queueEmpty = (count == '0);
  assign outValid   = !queueEmpty && !flushNow;
  assign fillReady  = (count != CW'(DEPTH)) && !flushNow;

  assign ctl.flush = flushNow;
  assign ctl.pop   = outValid && outReady;
  assign ctl.push  = fillValid && fillReady;

  function automatic logic [PW-1:0] nextIdx(input logic [PW-1:0] idx);
    return (idx == PW'(DEPTH - 1)) ? '0 : idx + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flushNow) begin
      count <= '0;
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (ctl.push) wrIdx <= nextIdx(wrIdx);
      if (ctl.pop)  rdIdx <= nextIdx(rdIdx);
      if (ctl.push && !ctl.pop)      count <= count + CW'(1);
      else if (!ctl.push && ctl.pop) count <= count - CW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> count < CW'(DEPTH)); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> queueEmpty && !outValid); // R9
  AST_LEGACY_NO_STORE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && !redirectValid && !serialize) |-> !ctl.flush); // R8
endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 3,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WB = DW / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  pfq_strobe_t     ctl,
  input  logic [PW-1:0]   wrIdx,
  input  logic [PW-1:0]   rdIdx,
  input  logic            queueEmpty,
  input  logic [AW-1:0]   fillAddr,
  input  logic [DW-1:0]   fillData,
  input  logic            storeValid,
  input  logic [AW-1:0]   storeAddr,
  input  logic [LENW-1:0] storeLen,
  input  logic            redirectValid,
  input  logic [AW-1:0]   redirectAddr,
  output logic            storeHit,
  output logic [AW-1:0]   headAddr,
  output logic [DW-1:0]   headData,
  output logic [AW-1:0]   restartAddr
);
  logic [AW-1:0]    addrQ [DEPTH];
  logic [DW-1:0]    dataQ [DEPTH];
  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] hitVec;
  logic [AW-1:0]    nextAddrQ;
  logic [AW:0]      storeLo, storeHi;

  assign storeLo = {1'b0, storeAddr};
  assign storeHi = storeLo + (AW+1)'(storeLen);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [AW:0] entryLo, entryHi;
    assign entryLo   = {1'b0, addrQ[i]};
    assign entryHi   = entryLo + (AW+1)'(WB - 1);
    assign hitVec[i] = validQ[i] && (storeLo <= entryHi) && (entryLo <= storeHi);

    always_ff @(posedge clk) begin
      if (!rstN || ctl.flush) validQ[i] <= 1'b0;
      else if (ctl.push && wrIdx == PW'(i)) validQ[i] <= 1'b1;
      else if (ctl.pop && rdIdx == PW'(i)) validQ[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (ctl.push && wrIdx == PW'(i)) begin
        addrQ[i] <= fillAddr;
        dataQ[i] <= fillData;
      end
    end
  end

  assign storeHit    = storeValid && (|hitVec);
  assign headAddr    = addrQ[rdIdx];
  assign headData    = dataQ[rdIdx];
  assign restartAddr = redirectValid ? redirectAddr : (queueEmpty ? nextAddrQ : headAddr);

  always_ff @(posedge clk) begin
    if (!rstN)          nextAddrQ <= RESET_ADDR;
    else if (ctl.flush) nextAddrQ <= restartAddr;
    else if (ctl.pop)   nextAddrQ <= headAddr + AW'(WB);
  end

  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> validQ[rdIdx]); // R2
  AST_PUSH_FREE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> !validQ[wrIdx]); // R3
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush && redirectValid |=> nextAddrQ == $past(redirectAddr)); // R6
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 3,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            legacyMode,
  input  logic            fillValid,
  output logic            fillReady,
  input  logic [AW-1:0]   fillAddr,
  input  logic [DW-1:0]   fillData,
  output logic            outValid,
  input  logic            outReady,
  output logic [AW-1:0]   outAddr,
  output logic [DW-1:0]   outData,
  input  logic            storeValid,
  input  logic [AW-1:0]   storeAddr,
  input  logic [LENW-1:0] storeLen,
  input  logic            redirectValid,
  input  logic [AW-1:0]   redirectAddr,
  input  logic            serialize,
  output logic            restartValid,
  output logic [AW-1:0]   restartAddr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pfq_strobe_t   ctl;
  logic [PW-1:0] wrIdx, rdIdx;
  logic          queueEmpty, storeHit;

  pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .outReady(outReady),
    .storeHit(storeHit), .legacyMode(legacyMode), .redirectValid(redirectValid),
    .serialize(serialize), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .fillReady(fillReady), .outValid(outValid), .queueEmpty(queueEmpty)
  );

  pfq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LENW(LENW), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .queueEmpty(queueEmpty), .fillAddr(fillAddr), .fillData(fillData),
    .storeValid(storeValid), .storeAddr(storeAddr), .storeLen(storeLen),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr),
    .storeHit(storeHit), .headAddr(outAddr), .headData(outData),
    .restartAddr(restartAddr)
  );

  assign restartValid = ctl.flush;

  AST_STORE_HIT_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    (storeHit && !legacyMode) |-> restartValid && !outValid); // R4
  AST_SERIALIZE_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    serialize |-> restartValid && !fillReady); // R7
endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        legacyMode = 1'b0;
  logic        fillValid = 1'b0;
  logic        fillReady;
  logic [31:0] fillAddr = '0;
  logic [31:0] fillData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outAddr, outData;
  logic        stV = 1'b0;
  logic [31:0] stA = '0;
  logic [2:0]  stL = '0;
  logic        rdV = 1'b0;
  logic [31:0] rdA = '0;
  logic        ser = 1'b0;
  logic        restartValid;
  logic [31:0] restartAddr;

  always #5 clk = ~clk;

  prefetch_queue #(.DEPTH(8), .AW(32), .DW(32), .LENW(3), .RESET_ADDR(32'h1000)) uut (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .fillValid(fillValid), .fillReady(fillReady), .fillAddr(fillAddr), .fillData(fillData),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outData(outData),
    .storeValid(stV), .storeAddr(stA), .storeLen(stL),
    .redirectValid(rdV), .redirectAddr(rdA), .serialize(ser),
    .restartValid(restartValid), .restartAddr(restartAddr)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] qa[$];
  logic [31:0] qd[$];
  logic [31:0] nextA = 32'h1000;
  logic [31:0] fetchPc = 32'h1000;
  logic [15:0] gen = 16'h0;
  logic eOV, eFR, eRV, eHit, eWould;
  logic [31:0] eRA;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    longint sLo, sHi;
    sLo = longint'(stA);
    sHi = sLo + longint'(stL);
    eWould = 1'b0;
    if (stV)
      foreach (qa[k])
        if (sLo <= longint'(qa[k]) + 3 && longint'(qa[k]) <= sHi) eWould = 1'b1;
    eHit = eWould && !legacyMode;
    eRV  = eHit || rdV || ser;
    eOV  = (qa.size() > 0) && !eRV;
    eFR  = (qa.size() < 8) && !eRV;
    eRA  = rdV ? rdA : ((qa.size() > 0) ? qa[0] : nextA);
    check(outValid === eOV, eRV ? "R9 outValid in flush" : (eWould ? "R8 outValid legacy" : "R2 outValid"),
          32'(outValid), 32'(eOV));
    check(fillReady === eFR, eRV ? "R9 fillReady in flush" : "R3 fillReady", 32'(fillReady), 32'(eFR));
    check(restartValid === eRV,
          rdV ? "R6 restartValid" : (eHit ? "R4 restartValid" : (ser ? "R7 restartValid" :
          (eWould ? "R8 legacy no flush" : "R10 restartValid"))), 32'(restartValid), 32'(eRV));
    if (eRV) check(restartAddr === eRA, rdV ? "R6 restartAddr" : "R5 restartAddr", restartAddr, eRA);
    if (eOV) begin
      check(outAddr === qa[0], "R2 outAddr", outAddr, qa[0]);
      check(outData === qd[0], "R2 outData", outData, qd[0]);
    end
  endtask

  task automatic update();
    logic push, pop;
    push = fillValid && eFR;
    pop  = eOV && outReady;
    if (eRV) begin
      qa.delete();
      qd.delete();
      nextA   = eRA;
      fetchPc = eRA;
    end else begin
      if (pop) begin
        nextA = qa[0] + 32'd4;
        void'(qa.pop_front());
        void'(qd.pop_front());
      end
      if (push) begin
        qa.push_back(fillAddr);
        qd.push_back(fillData);
        fetchPc = fetchPc + 32'd4;
      end
    end
  endtask

  task automatic step();
    fillAddr = fetchPc;
    fillData = {fetchPc[15:0], gen};
    #1 compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic storeStep(input logic [31:0] a, input logic [2:0] l);
    stV = 1'b1; stA = a; stL = l;
    step();
    stV = 1'b0;
    gen = gen + 16'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid === 1'b0, "R1 reset outValid", 32'(outValid), 32'd0);
    check(fillReady === 1'b1, "R1 reset fillReady", 32'(fillReady), 32'd1);
    check(restartValid === 1'b0, "R1 reset restartValid", 32'(restartValid), 32'd0);
    @(negedge clk);

    // R3: fill to capacity with the decoder stalled, then drain while full
    fillValid = 1'b1; outReady = 1'b0;
    repeat (10) step();
    check(qa.size() == 8 && fillReady === 1'b0, "R3 full", 32'(fillReady), 32'd0);
    outReady = 1'b1; step();
    outReady = 1'b0; step();

    // R4/R5: store touching only the last byte of the newest word
    fillValid = 1'b0;
    storeStep(qa[qa.size()-1] + 32'd3, 3'd0);

    // R10 then R4: store just below the oldest word, then one straddling into it
    fillValid = 1'b1; repeat (5) step();
    fillValid = 1'b0;
    storeStep(qa[0] - 32'd1, 3'd0);
    storeStep(qa[0] - 32'd2, 3'd2);

    // R9: decoder ready in the same cycle a store hits the oldest word
    fillValid = 1'b1; repeat (4) step();
    fillValid = 1'b0; outReady = 1'b1;
    storeStep(qa[0], 3'd7);
    outReady = 1'b0;

    // R10: store while the queue is empty
    storeStep(32'h1000, 3'd7);

    // R8: legacy mode keeps stale words and delivers them; redirect then flushes (R6)
    fillValid = 1'b1; repeat (6) step();
    fillValid = 1'b0; legacyMode = 1'b1;
    storeStep(qa[1], 3'd3);
    storeStep(qa[0], 3'd7);
    outReady = 1'b1; repeat (2) step();
    outReady = 1'b0;
    rdV = 1'b1; rdA = 32'h2000; step(); rdV = 1'b0;
    legacyMode = 1'b0;

    // R7/R5: serialize with empty queue restarts after last delivered word
    fillValid = 1'b1; repeat (3) step();
    fillValid = 1'b0; outReady = 1'b1; repeat (4) step();
    outReady = 1'b0;
    ser = 1'b1; step(); ser = 1'b0;

    // R6: redirect and store hit in the same cycle, redirect target wins
    fillValid = 1'b1; repeat (4) step();
    fillValid = 1'b0;
    rdV = 1'b1; rdA = 32'h3000;
    storeStep(qa[0], 3'd1);
    rdV = 1'b0;
    ser = 1'b1; rdV = 1'b1; rdA = 32'h3100; step(); ser = 1'b0; rdV = 1'b0;

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 250) legacyMode = ~legacyMode;
      fillValid = ($urandom % 4) != 0;
      outReady  = ($urandom % 3) != 0;
      stV = ($urandom % 5) == 0;
      if (qa.size() > 0 && ($urandom % 2) == 0)
        stA = qa[$urandom % qa.size()] + 32'($urandom % 11) - 32'd6;
      else
        stA = 32'h1000 + 32'($urandom % 8192);
      stL = 3'($urandom % 8);
      rdV = ($urandom % 40) == 0;
      rdA = 32'h2000 + 32'(($urandom % 64) * 4);
      ser = ($urandom % 60) == 0;
      step();
      if (stV) gen = gen + 16'd1;
    end
    stV = 1'b0; rdV = 1'b0; ser = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule